// File: doc/BRIEF.md
# Reference Selection Mode Controller

This block chooses the operating mode of a clock synchroniser that can follow either of two timing references. On every clock edge it looks at a select input, a force-free-run input, an output-disable input, an asynchronous reset, and the activity and in-range flags of each reference. From these it produces a registered mode code (locked to A, locked to B, free run, or unstable), a free-run status bit, an alarm bit, an output-enable bit, and the index of the reference that should feed the phase detector.

A reference counts as good only when it is both active and within range. A clean lock needs both references to be good. If the selected reference is healthy but its backup is missing, the block still raises the alarm. Free run is entered automatically only when neither reference is good. It can also be forced from outside.

Whenever the chosen reference index changes, a qualification timer starts. While it runs, the external loss-of-lock input cannot raise the alarm. The timer length is a parameter counted in system-clock cycles, so a simulation can use a short interval and silicon can use about half a second.

Top module: `refSelMode`

## Requirements
- R1: `refIdx` is registered and equals the value `selB` had before the last clock edge, in every mode: 0 selects reference A and 1 selects reference B.
- R2: With `forceFree` at 1, the next edge gives `mode` = 2 (free run), `freeRunStat` = 1 and `alarm` = 1, whatever the reference flags are.
- R3: If `forceFree` is 0 and neither reference is good, the next edge gives `mode` = 2, `freeRunStat` = 1 and `alarm` = 1.
- R4: If `forceFree` is 0 and both references are good, the next edge gives `mode` = 0 (locked A) when `selB` is 0 and `mode` = 1 (locked B) when `selB` is 1. In both cases `freeRunStat` = 0, and `alarm` equals the loss-of-lock term described in R8.
- R5: If `forceFree` is 0 and exactly one reference is good, which may be the selected one or the other one, the next edge gives `mode` = 3 (unstable), `alarm` = 1 and `freeRunStat` = 0.
- R6: `outEnable` is registered as the inverse of `outDisable`.
- R7: While `rst` is 1, all other inputs are overridden. The outputs are `mode` = 2, `freeRunStat` = 1, `alarm` = 1, `outEnable` = 0 and `refIdx` = 0, and the qualification timer is idle.
- R8: `lockLost` raises the alarm except during blanking. Blanking covers the edge on which `refIdx` takes a new value and the following `QUAL_CYCLES` edges. A new switch during blanking restarts the interval.
- R9: Reference n is good only when `refActive[n]` and `refInRange[n]` are both 1, with bit 0 for A and bit 1 for B. An active reference that is out of range behaves exactly like a lost one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| selB | input | 1 | Reference select: 0 = A, 1 = B |
| forceFree | input | 1 | Force free-run mode when 1 |
| outDisable | input | 1 | Disables the clock outputs when 1 |
| refActive | input | 2 | Activity flag per reference (bit 0 = A, bit 1 = B) |
| refInRange | input | 2 | Frequency-in-range flag per reference |
| lockLost | input | 1 | Loss-of-lock indication from the phase loop |
| mode | output | 2 | 0 locked A, 1 locked B, 2 free run, 3 unstable |
| freeRunStat | output | 1 | Free-run status |
| alarm | output | 1 | Loss of reference or loss of lock |
| outEnable | output | 1 | Output driver enable |
| refIdx | output | 1 | Reference index for the phase detector |

## Verification
Several kinds of internal fault are visible at the ports. A stuck or miscounting qualification timer appears as an alarm that rises too early or too late after a `refIdx` change while `lockLost` is held. An error in a restart would only show up when a second switch lands inside the window. A wrong decision in the mode logic shows up on `mode`, `alarm` or `freeRunStat` one edge after the reference flags change. The bench therefore compares every output every cycle against a model, so a fault is reported within one cycle of the first input pattern that exposes it.

// File: rtl/refSelPkg.sv
package refSelPkg;
  typedef enum logic [1:0] {
    MODE_LOCK_A   = 2'd0,
    MODE_LOCK_B   = 2'd1,
    MODE_FREE     = 2'd2,
    MODE_UNSTABLE = 2'd3
  } modeT;

  typedef struct packed {
    logic qualLoad;  // restart the qualification timer
    logic idxNext;   // reference index to register
  } ctlStrobeT;
endpackage

// File: rtl/refQual.sv
module refQual (
  input  logic active,
  input  logic inRange,
  output logic good
);
  // out of range counts the same as absent
  assign good = active & inRange;
endmodule

// File: rtl/refSelDatapath.sv
module refSelDatapath #(
  parameter int unsigned QUAL_CYCLES = 62_500_000,
  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  refSelPkg::ctlStrobeT  strobe,
  output logic                  idxQ,
  output logic                  blanking
);
  logic [CNT_W-1:0] qualCnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idxQ    <= 1'b0;
      qualCnt <= '0;
    end else begin
      idxQ <= strobe.idxNext;
      if (strobe.qualLoad)
        qualCnt <= CNT_W'(QUAL_CYCLES);
      else if (qualCnt != '0)
        qualCnt <= qualCnt - CNT_W'(1);
    end
  end

  assign blanking = (qualCnt != '0);

  // R8: timer counts down one per edge unless restarted
  assert_timer_count_R8: assert property (@(posedge clk) disable iff (rst)
    (qualCnt != '0 && !strobe.qualLoad) |=> (qualCnt == $past(qualCnt) - CNT_W'(1)));

  // R8: a restart always reloads the full interval
  assert_timer_load_R8: assert property (@(posedge clk) disable iff (rst)
    strobe.qualLoad |=> (qualCnt == CNT_W'(QUAL_CYCLES)));

  // R1: index register follows the requested index
  assert_idx_follow_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (idxQ == $past(strobe.idxNext)));
endmodule

// File: rtl/refSelCtrl.sv
module refSelCtrl #(
  parameter int unsigned NUM_REFS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  selB,
  input  logic                  forceFree,
  input  logic                  outDisable,
  input  logic [NUM_REFS-1:0]   refGood,
  input  logic                  lockLost,
  input  logic                  idxQ,
  input  logic                  blanking,
  output refSelPkg::ctlStrobeT  strobe,
  output refSelPkg::modeT       modeQ,
  output logic                  freeRunQ,
  output logic                  alarmQ,
  output logic                  outEnQ
);
  import refSelPkg::*;

  logic  selGood, altGood, swEvent, blankNow, lorTerm, frNext, alarmNext;
  modeT  modeNext;

  assign selGood = refGood[selB];
  assign altGood = refGood[~selB];
  assign swEvent = (selB != idxQ);
  assign blankNow = swEvent | blanking;

  always_comb begin
    strobe.qualLoad = swEvent;
    strobe.idxNext  = selB;
  end

  always_comb begin
    modeNext = MODE_UNSTABLE;
    frNext   = 1'b0;
    lorTerm  = 1'b1;
    if (forceFree || refGood == '0) begin
      modeNext = MODE_FREE;
      frNext   = 1'b1;
    end else if (selGood && altGood) begin
      modeNext = selB ? MODE_LOCK_B : MODE_LOCK_A;
      lorTerm  = 1'b0;
    end
  end

  assign alarmNext = lorTerm | (lockLost & ~blankNow);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      modeQ    <= MODE_FREE;
      freeRunQ <= 1'b1;
      alarmQ   <= 1'b1;
      outEnQ   <= 1'b0;
    end else begin
      modeQ    <= modeNext;
      freeRunQ <= frNext;
      alarmQ   <= alarmNext;
      outEnQ   <= ~outDisable;
    end
  end

  assert_forced_free_R2: assert property (@(posedge clk) disable iff (rst)
    forceFree |=> (modeQ == MODE_FREE && freeRunQ && alarmQ));

  assert_auto_free_R3: assert property (@(posedge clk) disable iff (rst)
    (refGood == '0) |=> (modeQ == MODE_FREE && freeRunQ && alarmQ));

  assert_clean_lock_R4: assert property (@(posedge clk) disable iff (rst)
    (!forceFree && &refGood && !lockLost) |=>
      (!alarmQ && !freeRunQ && modeQ == ($past(selB) ? MODE_LOCK_B : MODE_LOCK_A)));

  assert_unstable_R5: assert property (@(posedge clk) disable iff (rst)
    (!forceFree && $countones(refGood) == 1) |=> (modeQ == MODE_UNSTABLE && alarmQ && !freeRunQ));

  assert_out_disable_R6: assert property (@(posedge clk) disable iff (rst)
    outDisable |=> !outEnQ);

  assert_switch_blank_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.qualLoad && !forceFree && &refGood) |=> !alarmQ);
endmodule

// File: rtl/refSelMode.sv
module refSelMode #(
  parameter int unsigned QUAL_CYCLES = 62_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       selB,
  input  logic       forceFree,
  input  logic       outDisable,
  input  logic [1:0] refActive,
  input  logic [1:0] refInRange,
  input  logic       lockLost,
  output logic [1:0] mode,
  output logic       freeRunStat,
  output logic       alarm,
  output logic       outEnable,
  output logic       refIdx
);
  import refSelPkg::*;

  localparam int unsigned NUM_REFS = 2;

  logic [NUM_REFS-1:0] refGood;
  ctlStrobeT           strobe;
  logic                idxQ, blanking;
  modeT                modeQ;

  for (genvar i = 0; i < NUM_REFS; i++) begin : gQual
    refQual uQual (
      .active (refActive[i]),
      .inRange(refInRange[i]),
      .good   (refGood[i])
    );
  end

  refSelCtrl #(.NUM_REFS(NUM_REFS)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .selB      (selB),
    .forceFree (forceFree),
    .outDisable(outDisable),
    .refGood   (refGood),
    .lockLost  (lockLost),
    .idxQ      (idxQ),
    .blanking  (blanking),
    .strobe    (strobe),
    .modeQ     (modeQ),
    .freeRunQ  (freeRunStat),
    .alarmQ    (alarm),
    .outEnQ    (outEnable)
  );

  refSelDatapath #(.QUAL_CYCLES(QUAL_CYCLES)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .idxQ    (idxQ),
    .blanking(blanking)
  );

  assign mode   = modeQ;
  assign refIdx = idxQ;
endmodule

// File: tb/refSelMode_test.sv
`timescale 1ns/1ps
module refSelMode_test;
  localparam int unsigned QUAL = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic selB = 1'b0, forceFree = 1'b0, outDisable = 1'b0, lockLost = 1'b0;
  logic [1:0] refActive = 2'b11, refInRange = 2'b11;
  logic [1:0] mode;
  logic freeRunStat, alarm, outEnable, refIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [1:0] mMode = 2'd2;
  logic mFr = 1'b1, mAlarm = 1'b1, mOe = 1'b0, mIdx = 1'b0;
  int   mCnt = 0;
  string mTag = "R7";
  string aTag = "R7";

  always #2 clk = ~clk;

  refSelMode #(.QUAL_CYCLES(QUAL)) uut (
    .clk(clk), .rst(rst), .selB(selB), .forceFree(forceFree),
    .outDisable(outDisable), .refActive(refActive), .refInRange(refInRange),
    .lockLost(lockLost), .mode(mode), .freeRunStat(freeRunStat),
    .alarm(alarm), .outEnable(outEnable), .refIdx(refIdx)
  );

  function automatic logic [1:0] goodOf(input logic [1:0] act, input logic [1:0] rng);
    return act & rng;  // R9
  endfunction

  task automatic modelReset();
    mMode = 2'd2; mFr = 1'b1; mAlarm = 1'b1; mOe = 1'b0; mIdx = 1'b0; mCnt = 0;
    mTag = "R7"; aTag = "R7";
  endtask

  task automatic modelStep();
    logic [1:0] g;
    logic sw, blank, lor, sg, og;
    g     = goodOf(refActive, refInRange);
    sw    = (selB != mIdx);
    blank = sw || (mCnt != 0);
    sg    = g[selB];
    og    = g[~selB];
    lor   = 1'b1;
    mFr   = 1'b0;
    if (forceFree) begin
      mMode = 2'd2; mFr = 1'b1; mTag = "R2"; aTag = "R2";
    end else if (g == 2'b00) begin
      mMode = 2'd2; mFr = 1'b1; mTag = "R3"; aTag = "R3";
    end else if (sg && og) begin
      mMode = {1'b0, selB}; lor = 1'b0; mTag = "R4"; aTag = "R8";
    end else begin
      mMode = 2'd3; mTag = "R5"; aTag = "R5";
    end
    if (refActive != refInRange && !forceFree) mTag = "R9";
    mAlarm = lor | (lockLost & ~blank);
    mCnt   = sw ? int'(QUAL) : (mCnt != 0 ? mCnt - 1 : 0);
    mIdx   = selB;
    mOe    = ~outDisable;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk(mTag, "mode", int'(mode), int'(mMode));
    chk(mTag, "freeRunStat", int'(freeRunStat), int'(mFr));
    chk(aTag, "alarm", int'(alarm), int'(mAlarm));
    chk("R6", "outEnable", int'(outEnable), int'(mOe));
    chk("R1", "refIdx", int'(refIdx), int'(mIdx));
  endtask

  // one clock: inputs already set at negedge; advance, update model, check
  task automatic cycle();
    @(posedge clk);
    if (rst) modelReset(); else modelStep();
    #1;
    checkAll();
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    cycles(3);                     // R7: reset state held
    chk("R7", "reset mode", int'(mode), 2);
    chk("R7", "reset outEnable", int'(outEnable), 0);
    rst = 1'b0;
    cycles(QUAL + 4);              // both good, sel A: clean lock R4
    chk("R4", "lock A mode", int'(mode), 0);

    // R8: switch to B with lockLost held; alarm masked QUAL+1 edges
    lockLost = 1'b1;
    selB = 1'b1;
    cycle();
    chk("R8", "alarm masked at switch edge", int'(alarm), 0);
    selB = 1'b1;
    cycles(QUAL);
    chk("R8", "alarm masked at window end", int'(alarm), 0);
    cycle();
    chk("R8", "alarm after window", int'(alarm), 1);
    lockLost = 1'b0;
    cycles(2);

    // R8: restart inside window
    lockLost = 1'b1;
    selB = 1'b0; cycles(4);
    selB = 1'b1; cycles(QUAL);
    chk("R8", "alarm masked after restart", int'(alarm), 0);
    cycles(2);
    lockLost = 1'b0;

    // R5: selected good, other lost
    refActive = 2'b10; cycle();
    chk("R5", "unstable alt lost", int'(mode), 3);
    // R9: active but out of range on A
    refActive = 2'b11; refInRange = 2'b10; cycle();
    chk("R9", "out of range gives unstable", int'(mode), 3);
    // R3: both bad
    refInRange = 2'b00; cycle();
    chk("R3", "auto free run", int'(freeRunStat), 1);
    refInRange = 2'b11;
    // R2: forced
    forceFree = 1'b1; cycle();
    chk("R2", "forced free alarm", int'(alarm), 1);
    forceFree = 1'b0;
    // R6
    outDisable = 1'b1; cycle();
    chk("R6", "disabled", int'(outEnable), 0);
    outDisable = 1'b0; cycles(2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) selB = ~selB;
      forceFree  = ($urandom_range(0, 15) == 0);
      outDisable = ($urandom_range(0, 9) == 0);
      lockLost   = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 7) == 0) begin
        refActive  = 2'($urandom_range(0, 3));
        refInRange = 2'($urandom_range(0, 3));
      end else if ($urandom_range(0, 3) == 0) begin
        refActive = 2'b11; refInRange = 2'b11;
      end
      rst = ($urandom_range(0, 499) == 0);  // R7 mid-run
      cycle();
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule